// File: doc/BRIEF.md
# Flash Page Parity-Code Corrector

This block checks one 512-byte flash data block. It takes the 24-bit check code that was stored in the spare area. It also takes the 24-bit code that the data path calculated again over the same block. From these two codes it decides which of five cases applies:

- the data is clean;
- the stored code was never written and may be ignored;
- one data bit is wrong and can be repaired;
- the fault is in the stored code itself;
- the block cannot be repaired.

When one data bit is wrong, the block also gives the byte offset and the bit number to invert. Inverting that bit in the buffered data is left to the logic around the block.

A request is a one-cycle start strobe, with both codes and a configuration bit present in the same cycle. The configuration bit lets an unwritten (all-ones) stored code be accepted as blank. The verdict comes from a register one cycle later, together with a one-cycle done pulse. It then holds until the next request.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: While reset is held and after it, before any request: done is 0, status is 0 and both position outputs are 0.
- R2: Each start strobe gives a done pulse exactly one cycle later, and done is never high in any other cycle. The verdict is present in the same cycle as done.
- R3: If the stored and calculated codes are equal, status is CLEAN (0). This holds even when the stored code is all ones and the ignore option is on.
- R4: If the codes differ, the stored code is 0xFFFFFF and the ignore option is 1, status is BLANK (1).
- R5: If the ignore option is 0, an all-ones stored code gets no special treatment and is classified like any other code.
- R6: The difference code s is stored XOR calculated. Syndrome byte k is s[8k+7:8k]. If every bit pair (1:0, 3:2, 5:4, 7:6) in all three syndrome bytes holds two unequal bits, status is FIXABLE (2). The byte offset is then {s[17], s[15], s[13], s[11], s[9], s[7], s[5], s[3], s[1]}, most significant bit first.
- R7: With status FIXABLE, the bit number is {s[23], s[21], s[19]}, most significant bit first.
- R8: If the syndrome is not FIXABLE and exactly one of its 24 bits is set, status is CODE_FAULT (3).
- R9: Any other nonzero syndrome that R4 does not cover gives status FATAL (4).
- R10: Whenever status is not FIXABLE, the byte offset and the bit number are both 0.
- R11: In cycles without a start strobe, all result outputs keep their values, whatever the code inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| stored_code_i | input | 24 | Check code read back from the spare area |
| calc_code_i | input | 24 | Check code calculated over the data block |
| ignore_blank_i | input | 1 | Accept an all-ones stored code as blank |
| done_o | output | 1 | One-cycle pulse: the verdict is valid |
| status_o | output | 3 | Verdict code 0 to 4 |
| byte_idx_o | output | 9 | Byte offset of the bad data bit |
| bit_idx_o | output | 3 | Bit number within that byte |

## Verification
The directed stimulus has five parts, each with its own purpose:

- **Built single-bit syndromes.** For a random offset and bit, plus the extreme positions 0/0 and 511/7, these test the position mapping bit by bit.
- **Single set syndrome bits.** These separate a fault in the stored code from a repairable data fault.
- **Equal codes and all-ones stored codes.** These are tried with the ignore option both on and off, which tests the order of the checks.
- **Random code pairs.** These almost always fail the pair rule and so exercise the fatal path.
- **Random code inputs after each verdict.** Changing the inputs without a start strobe shows that the outputs hold.

// File: rtl/ecc_fix_pkg.sv
// Shared constants and the verdict type for the parity-code corrector.
package ecc_fix_pkg;
    localparam int CODE_BYTES  = 3;
    localparam int CODE_W      = 8 * CODE_BYTES;
    localparam int PAIRS_PER_B = 4;
    localparam int ODD_BITS    = PAIRS_PER_B * CODE_BYTES;
    localparam int BIT_IDX_W   = 3;
    localparam int BYTE_IDX_W  = ODD_BITS - BIT_IDX_W;
    localparam int STATUS_W    = 3;

    typedef enum logic [STATUS_W-1:0] {
        ST_CLEAN      = 3'd0,
        ST_BLANK      = 3'd1,
        ST_FIXABLE    = 3'd2,
        ST_CODE_FAULT = 3'd3,
        ST_FATAL      = 3'd4
    } fix_status_e;
endpackage

// File: rtl/ecc_syndrome_gen.sv
// Forms the difference code between stored and calculated check codes and
// derives the flags the classifier needs. Purely combinational.
// Assumes byte k of a code sits at bits 8k+7:8k.
module ecc_syndrome_gen #(
    parameter int CODE_BYTES = ecc_fix_pkg::CODE_BYTES,
    parameter int CODE_W     = 8 * CODE_BYTES
) (
    input  logic [CODE_W-1:0] stored_i,
    input  logic [CODE_W-1:0] calc_i,
    output logic [CODE_W-1:0] syn_o,
    output logic              zero_o,
    output logic              blank_o,
    output logic              pairs_ok_o,
    output logic              single_o
);
    localparam int NPAIRS = CODE_W / 2;

    logic [NPAIRS-1:0] pair_diff;

    // Difference code.
    always_comb syn_o = stored_i ^ calc_i;

    // One flag per bit pair: the two bits of the pair disagree.
    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        assign pair_diff[p] = syn_o[2*p+1] ^ syn_o[2*p];
    end

    // Summary flags for the classifier.
    always_comb begin
        zero_o     = (syn_o == '0);
        blank_o    = (stored_i == '1);
        pairs_ok_o = &pair_diff;
        single_o   = !zero_o && ((syn_o & (syn_o - 1'b1)) == '0);
    end
endmodule

// File: rtl/ecc_locator.sv
// Gathers the odd bit of every syndrome pair and splits the gathered vector
// into the byte offset (low part) and the bit number (high part).
// Assumes the byte offset plus the bit number use exactly one bit per pair.
module ecc_locator #(
    parameter int CODE_BYTES = ecc_fix_pkg::CODE_BYTES,
    parameter int BIT_IDX_W  = ecc_fix_pkg::BIT_IDX_W,
    parameter int CODE_W     = 8 * CODE_BYTES,
    parameter int ODD_BITS   = 4 * CODE_BYTES,
    parameter int BYTE_IDX_W = ODD_BITS - BIT_IDX_W
) (
    input  logic [CODE_W-1:0]     syn_i,
    output logic [BYTE_IDX_W-1:0] byte_idx_o,
    output logic [BIT_IDX_W-1:0]  bit_idx_o
);
    logic [ODD_BITS-1:0] odd_bits;

    // Odd bit of pair k lands in position k of the gathered vector.
    for (genvar k = 0; k < ODD_BITS; k++) begin : g_odd
        assign odd_bits[k] = syn_i[2*k+1];
    end

    // Split into the two position fields.
    always_comb begin
        byte_idx_o = odd_bits[BYTE_IDX_W-1:0];
        bit_idx_o  = odd_bits[ODD_BITS-1:BYTE_IDX_W];
    end
endmodule

// File: rtl/ecc_classifier.sv
// Priority decision over the syndrome flags. Order of the checks: clean,
// blank (when allowed), fixable, code fault, fatal. Positions pass through
// only for a fixable verdict and are forced to zero otherwise.
module ecc_classifier #(
    parameter int BYTE_IDX_W = ecc_fix_pkg::BYTE_IDX_W,
    parameter int BIT_IDX_W  = ecc_fix_pkg::BIT_IDX_W
) (
    input  logic                        zero_i,
    input  logic                        blank_i,
    input  logic                        ignore_blank_i,
    input  logic                        pairs_ok_i,
    input  logic                        single_i,
    input  logic [BYTE_IDX_W-1:0]       byte_idx_i,
    input  logic [BIT_IDX_W-1:0]        bit_idx_i,
    output ecc_fix_pkg::fix_status_e    status_o,
    output logic [BYTE_IDX_W-1:0]       byte_idx_o,
    output logic [BIT_IDX_W-1:0]        bit_idx_o
);
    import ecc_fix_pkg::*;

    // Verdict selection in fixed priority order.
    always_comb begin
        byte_idx_o = '0;
        bit_idx_o  = '0;
        if (zero_i) begin
            status_o = ST_CLEAN;
        end else if (blank_i && ignore_blank_i) begin
            status_o = ST_BLANK;
        end else if (pairs_ok_i) begin
            status_o   = ST_FIXABLE;
            byte_idx_o = byte_idx_i;
            bit_idx_o  = bit_idx_i;
        end else if (single_i) begin
            status_o = ST_CODE_FAULT;
        end else begin
            status_o = ST_FATAL;
        end
    end
endmodule

// File: rtl/ecc_syndrome_corrector.sv
// Top level: compares stored and calculated check codes of one data block
// and registers a verdict one cycle after start. The result holds until the
// next start. Synchronous active-low reset.
module ecc_syndrome_corrector (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [23:0] stored_code_i,
    input  logic [23:0] calc_code_i,
    input  logic        ignore_blank_i,
    output logic        done_o,
    output logic [2:0]  status_o,
    output logic [8:0]  byte_idx_o,
    output logic [2:0]  bit_idx_o
);
    import ecc_fix_pkg::*;

    logic [CODE_W-1:0]     syn;
    logic                  f_zero, f_blank, f_pairs, f_single;
    logic [BYTE_IDX_W-1:0] loc_byte, dec_byte;
    logic [BIT_IDX_W-1:0]  loc_bit, dec_bit;
    fix_status_e           dec_status;
    fix_status_e           status_q;

    ecc_syndrome_gen #(.CODE_BYTES(CODE_BYTES)) u_syn (
        .stored_i   (stored_code_i),
        .calc_i     (calc_code_i),
        .syn_o      (syn),
        .zero_o     (f_zero),
        .blank_o    (f_blank),
        .pairs_ok_o (f_pairs),
        .single_o   (f_single)
    );

    ecc_locator #(.CODE_BYTES(CODE_BYTES), .BIT_IDX_W(BIT_IDX_W)) u_loc (
        .syn_i      (syn),
        .byte_idx_o (loc_byte),
        .bit_idx_o  (loc_bit)
    );

    ecc_classifier #(.BYTE_IDX_W(BYTE_IDX_W), .BIT_IDX_W(BIT_IDX_W)) u_cls (
        .zero_i         (f_zero),
        .blank_i        (f_blank),
        .ignore_blank_i (ignore_blank_i),
        .pairs_ok_i     (f_pairs),
        .single_i       (f_single),
        .byte_idx_i     (loc_byte),
        .bit_idx_i      (loc_bit),
        .status_o       (dec_status),
        .byte_idx_o     (dec_byte),
        .bit_idx_o      (dec_bit)
    );

    // Result register: load on start, otherwise hold; done pulses once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            status_q   <= ST_CLEAN;
            byte_idx_o <= '0;
            bit_idx_o  <= '0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                status_q   <= dec_status;
                byte_idx_o <= dec_byte;
                bit_idx_o  <= dec_bit;
            end
        end
    end

    // Verdict output.
    assign status_o = status_q;
endmodule

// File: rtl/ecc_syndrome_corrector_chk.sv
// Checker for the corrector's port timing and verdict rules. Attached by
// the bind statement below.
module ecc_syndrome_corrector_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [23:0] stored_code_i,
    input logic [23:0] calc_code_i,
    input logic        ignore_blank_i,
    input logic        done_o,
    input logic [2:0]  status_o,
    input logic [8:0]  byte_idx_o,
    input logic [2:0]  bit_idx_o
);
    a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    a_r2_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    a_r3_equal_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stored_code_i == calc_code_i) |=> status_o == 3'd0);

    a_r4_blank_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ignore_blank_i && stored_code_i == 24'hFFFFFF &&
         calc_code_i != 24'hFFFFFF) |=> status_o == 3'd1);

    a_r8_single_bit_code_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && $countones(stored_code_i ^ calc_code_i) == 1 &&
         !(ignore_blank_i && stored_code_i == 24'hFFFFFF)) |=> status_o == 3'd3);

    a_r9_status_range: assert property (@(posedge clk) disable iff (!rst_n)
        status_o <= 3'd4);

    a_r10_positions_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o != 3'd2 |-> (byte_idx_o == 9'd0 && bit_idx_o == 3'd0));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(status_o) && $stable(byte_idx_o) && $stable(bit_idx_o)));
endmodule

bind ecc_syndrome_corrector ecc_syndrome_corrector_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .stored_code_i  (stored_code_i),
    .calc_code_i    (calc_code_i),
    .ignore_blank_i (ignore_blank_i),
    .done_o         (done_o),
    .status_o       (status_o),
    .byte_idx_o     (byte_idx_o),
    .bit_idx_o      (bit_idx_o)
);

// File: tb/ecc_syndrome_corrector_tb_top.sv
`timescale 1ns/1ps
module ecc_syndrome_corrector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] stored_code_i = '0;
    logic [23:0] calc_code_i = '0;
    logic        ignore_blank_i = 1'b0;
    logic        done_o;
    logic [2:0]  status_o;
    logic [8:0]  byte_idx_o;
    logic [2:0]  bit_idx_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ecc_syndrome_corrector dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected verdict from the requirement text.
    function automatic logic [2:0] exp_status(logic [23:0] st, logic [23:0] ca, logic ign);
        logic [23:0] s;
        logic ok;
        s = st ^ ca;
        if (s == 0) return 3'd0;                           // R3
        if (ign && st == 24'hFFFFFF) return 3'd1;          // R4
        ok = 1'b1;
        for (int i = 0; i < 12; i++) if (s[2*i] == s[2*i+1]) ok = 1'b0;
        if (ok) return 3'd2;                               // R6
        if ($countones(s) == 1) return 3'd3;               // R8
        return 3'd4;                                       // R9
    endfunction

    function automatic logic [8:0] exp_byte(logic [23:0] s);
        return {s[17], s[15], s[13], s[11], s[9], s[7], s[5], s[3], s[1]};
    endfunction

    function automatic logic [2:0] exp_bit(logic [23:0] s);
        return {s[23], s[21], s[19]};
    endfunction

    // Builds a fixable syndrome that points at the given byte and bit.
    function automatic logic [23:0] make_syn(logic [8:0] byt, logic [2:0] bt);
        logic [11:0] odd;
        logic [23:0] s;
        odd = {bt, byt};
        for (int k = 0; k < 12; k++) begin
            s[2*k+1] = odd[k];
            s[2*k]   = ~odd[k];
        end
        return s;
    endfunction

    // One request, then verdict check, then hold check with scrambled inputs.
    task automatic run(input logic [23:0] st, input logic [23:0] ca, input logic ign);
        logic [2:0] es;
        logic [8:0] eb;
        logic [2:0] ei;
        es = exp_status(st, ca, ign);
        eb = (es == 3'd2) ? exp_byte(st ^ ca) : 9'd0;
        ei = (es == 3'd2) ? exp_bit(st ^ ca) : 3'd0;
        @(negedge clk);
        stored_code_i = st; calc_code_i = ca; ignore_blank_i = ign; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 done", done_o, 1);
        check("R3/R4/R6/R8/R9 status", status_o, es);
        check("R6/R10 byte", byte_idx_o, eb);
        check("R7/R10 bit", bit_idx_o, ei);
        stored_code_i = $urandom; calc_code_i = $urandom; ignore_blank_i = $urandom;
        @(negedge clk);
        check("R2 single pulse", done_o, 0);
        check("R11 hold status", status_o, es);
        check("R11 hold byte", byte_idx_o, eb);
    endtask

    initial begin
        logic [23:0] c;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 done", done_o, 0);
        check("R1 status", status_o, 0);
        check("R1 byte", byte_idx_o, 0);
        check("R1 bit", bit_idx_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {done_o, status_o, byte_idx_o, bit_idx_o}, 0);
        // R3 equal codes, including all-ones with ignore on
        run(24'h123456, 24'h123456, 1'b0);
        run(24'hFFFFFF, 24'hFFFFFF, 1'b1);
        // R4 blank accepted, R5 blank not accepted
        run(24'hFFFFFF, 24'h0A0B0C, 1'b1);
        run(24'hFFFFFF, 24'h0A0B0C, 1'b0);
        run(24'hFFFFFF, 24'hFFFFFF ^ make_syn(9'd77, 3'd5), 1'b0);
        // R6/R7 extreme positions
        run(24'h5A5A5A ^ make_syn(9'd0, 3'd0), 24'h5A5A5A, 1'b0);
        run(24'h00C3F0 ^ make_syn(9'd511, 3'd7), 24'h00C3F0, 1'b1);
        // R8 single set syndrome bits at every position
        for (int b = 0; b < 24; b++) run(24'h3C3C3C ^ (24'h1 << b), 24'h3C3C3C, 1'b0);
        // R9 two-bit syndrome
        run(24'h000003, 24'h000000, 1'b0);
        // Random fixable patterns
        for (int i = 0; i < 200; i++) begin
            c = $urandom;
            run(c ^ make_syn(9'($urandom), 3'($urandom)), c, 1'($urandom));
        end
        // Random pairs
        for (int i = 0; i < 300; i++) run(24'($urandom), 24'($urandom), 1'($urandom));
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule